// File: doc/BRIEF.md
# Single-Cycle Integer Execute Unit

This block executes one 32-bit instruction word per clock from a compact load/store integer instruction set. Each word presented with its valid strobe is decoded, its operands are read from a 32-entry register file, and the result is committed at the next rising clock edge. The block handles register-to-register arithmetic and logic, an add with a 16-bit signed constant, logical shifts by a constant amount, and word loads and stores to a small data memory held inside the block.

The result path is visible at the ports in the same cycle as the instruction: the register write enable, destination index and write data, the effective memory address for loads and stores, and two fault flags. A register value can be read out by issuing an OR whose destination is register 0; the write is dropped, but the computed value still appears on the write data port.

Top module: `rexec_core`

## Requirements
- R1: Active-low reset clears every register and every data memory word to zero; while no valid instruction is present, regWrEn, illegalFlag and misalignFlag are low.
- R2: Register format is opcode[31:26]=0, rs[25:21], rt[24..16 as 20:16], rd[15:11], shamt[10:6], funct[5:0]; funct 32 adds rs and rt, funct 34 subtracts rt from rs, both wrapping modulo 2^32, written to rd.
- R3: Funct 36 gives rs AND rt, funct 37 gives rs OR rt, funct 39 gives NOT(rs OR rt), written to rd.
- R4: Funct 0 shifts rt left and funct 2 shifts rt right by shamt, filling vacated bits with zeros, written to rd.
- R5: Opcode 8 adds rs to imm[15:0] sign-extended from bit 15 and writes the sum to rt (bits 20:16).
- R6: Opcode 35 loads the memory word at byte address rs plus the sign-extended imm into rt; opcode 43 stores rt there; memAddr shows that address for both and is zero for other instructions; the word index is taken from address bits above bit 1, wrapping over the memory depth.
- R7: Register 0 reads as zero; a write to it is discarded and regWrEn stays low for it.
- R8: A load or store whose address has bit 1 or bit 0 set raises misalignFlag and changes neither register nor memory.
- R9: An opcode other than 0, 8, 35, 43, or a funct other than 0, 2, 32, 34, 36, 37, 39 under opcode 0, raises illegalFlag for that cycle and changes no register or memory word.
- R10: With instrValid low the instruction word has no effect: no write, no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instrWord | input | 32 | Instruction to execute |
| regWrEn | output | 1 | Register write takes place at the next edge |
| regWrAddr | output | 5 | Destination register index |
| regWrData | output | 32 | Result value (shown even when the write is dropped) |
| memAddr | output | 32 | Effective byte address of a load or store |
| misalignFlag | output | 1 | Load or store to a non-word-aligned address |
| illegalFlag | output | 1 | Unrecognised opcode or funct |

## Verification
Assertions watch, on every cycle, that no write reaches register 0, that a misaligned access, an illegal word or a missing valid strobe never produces a register or memory write, and that register and memory contents stay unchanged across any cycle without a write strobe. The arithmetic results, the field positions of each format, sign extension, store-then-load round trips, the memory index wrap and the clearing effect of reset can only be shown by the bench's instruction sequences and their observed results.

// File: rtl/rexec_pkg.sv
package rexec_pkg;

  localparam int XLEN = 32;
  localparam int REG_AW = 5;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;

  localparam logic [5:0] FN_SLL = 6'd0;
  localparam logic [5:0] FN_SRL = 6'd2;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_NOR = 6'd39;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLL, ALU_SRL
  } aluOpT;

  typedef struct packed {
    aluOpT aluOp;
    logic  useImm;
    logic  dstRt;
    logic  regWr;
    logic  memRd;
    logic  memWr;
    logic  illegal;
  } ctrlT;

endpackage

// File: rtl/rexec_ctrl.sv
module rexec_ctrl
  import rexec_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrlT       ctrl
);

  always_comb begin
    ctrl = '{aluOp: ALU_ADD, useImm: 1'b0, dstRt: 1'b0, regWr: 1'b0,
             memRd: 1'b0, memWr: 1'b0, illegal: 1'b0};
    case (opcode)
      OP_RTYPE: begin
        ctrl.regWr = 1'b1;
        case (funct)
          FN_ADD:  ctrl.aluOp = ALU_ADD;
          FN_SUB:  ctrl.aluOp = ALU_SUB;
          FN_AND:  ctrl.aluOp = ALU_AND;
          FN_OR:   ctrl.aluOp = ALU_OR;
          FN_NOR:  ctrl.aluOp = ALU_NOR;
          FN_SLL:  ctrl.aluOp = ALU_SLL;
          FN_SRL:  ctrl.aluOp = ALU_SRL;
          default: begin
            ctrl.regWr   = 1'b0;
            ctrl.illegal = 1'b1;
          end
        endcase
      end
      OP_ADDI: begin
        ctrl.useImm = 1'b1;
        ctrl.dstRt  = 1'b1;
        ctrl.regWr  = 1'b1;
      end
      OP_LOAD: begin
        ctrl.useImm = 1'b1;
        ctrl.dstRt  = 1'b1;
        ctrl.regWr  = 1'b1;
        ctrl.memRd  = 1'b1;
      end
      OP_STORE: begin
        ctrl.useImm = 1'b1;
        ctrl.memWr  = 1'b1;
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/rexec_dpath.sv
module rexec_dpath
  import rexec_pkg::*;
#(
  parameter int MEM_WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  ctrlT              ctrl,
  input  logic [REG_AW-1:0] rsIdx,
  input  logic [REG_AW-1:0] rtIdx,
  input  logic [REG_AW-1:0] rdIdx,
  input  logic [4:0]        shamt,
  input  logic [15:0]       imm16,
  output logic              regWrEn,
  output logic [REG_AW-1:0] regWrAddr,
  output logic [XLEN-1:0]   regWrData,
  output logic [XLEN-1:0]   memAddr,
  output logic              misalign
);

  localparam int REGS   = 1 << REG_AW;
  localparam int MEM_AW = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1;

  logic [REGS-1:0][XLEN-1:0]      rfArr;
  logic [MEM_WORDS-1:0][XLEN-1:0] memArr;

  logic [XLEN-1:0]   rsVal, rtVal, immExt, opB, aluRes, effAddr, memWord;
  logic [MEM_AW-1:0] memIdx;
  logic              isMem, commitOk, memWrEn;

  // operand read, register 0 hardwired to zero
  assign rsVal  = (rsIdx == '0) ? '0 : rfArr[rsIdx];
  assign rtVal  = (rtIdx == '0) ? '0 : rfArr[rtIdx];
  assign immExt = {{(XLEN-16){imm16[15]}}, imm16};
  assign opB    = ctrl.useImm ? immExt : rtVal;

  always_comb begin
    case (ctrl.aluOp)
      ALU_ADD: aluRes = rsVal + opB;
      ALU_SUB: aluRes = rsVal - opB;
      ALU_AND: aluRes = rsVal & opB;
      ALU_OR:  aluRes = rsVal | opB;
      ALU_NOR: aluRes = ~(rsVal | opB);
      ALU_SLL: aluRes = rtVal << shamt;
      ALU_SRL: aluRes = rtVal >> shamt;
      default: aluRes = rsVal + opB;
    endcase
  end

  // address generation and fault gating
  assign effAddr  = aluRes;
  assign isMem    = instrValid && !ctrl.illegal && (ctrl.memRd || ctrl.memWr);
  assign misalign = isMem && (effAddr[1:0] != 2'b00);
  assign memAddr  = isMem ? effAddr : '0;
  assign commitOk = instrValid && !ctrl.illegal && !misalign;
  assign memIdx   = effAddr[2 +: MEM_AW];
  assign memWord  = memArr[memIdx];

  assign regWrAddr = ctrl.dstRt ? rtIdx : rdIdx;
  assign regWrData = ctrl.memRd ? memWord : aluRes;
  assign regWrEn   = commitOk && ctrl.regWr && (regWrAddr != '0);
  assign memWrEn   = commitOk && ctrl.memWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rfArr <= '0;
    end else begin
      rfArr[0] <= '0;
      for (int i = 1; i < REGS; i++) begin
        if (regWrEn && (regWrAddr == REG_AW'(i))) rfArr[i] <= regWrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memArr <= '0;
    end else begin
      for (int w = 0; w < MEM_WORDS; w++) begin
        if (memWrEn && (memIdx == MEM_AW'(w))) memArr[w] <= rtVal;
      end
    end
  end

  // R7: no write is ever steered at register 0
  p_zero_dest_r7: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> regWrAddr != '0);

  // R8: a misaligned access commits nothing
  p_misalign_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> (!regWrEn && !memWrEn));

  // R9: an illegal word commits nothing
  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.illegal |-> (!regWrEn && !memWrEn));

  // R10: no strobe, no activity
  p_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |-> (!regWrEn && !memWrEn && !misalign));

  // R9: register contents hold when no write strobe
  p_reg_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(rfArr));

  // R6: memory contents hold when no store commits
  p_mem_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !memWrEn |=> $stable(memArr));

endmodule

// File: rtl/rexec_core.sv
module rexec_core
  import rexec_pkg::*;
#(
  parameter int MEM_WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [XLEN-1:0]   instrWord,
  output logic              regWrEn,
  output logic [REG_AW-1:0] regWrAddr,
  output logic [XLEN-1:0]   regWrData,
  output logic [XLEN-1:0]   memAddr,
  output logic              misalignFlag,
  output logic              illegalFlag
);

  ctrlT ctrl;

  rexec_ctrl ctrl_i (
    .opcode (instrWord[31:26]),
    .funct  (instrWord[5:0]),
    .ctrl   (ctrl)
  );

  rexec_dpath #(.MEM_WORDS(MEM_WORDS)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .instrValid (instrValid),
    .ctrl       (ctrl),
    .rsIdx      (instrWord[25:21]),
    .rtIdx      (instrWord[20:16]),
    .rdIdx      (instrWord[15:11]),
    .shamt      (instrWord[10:6]),
    .imm16      (instrWord[15:0]),
    .regWrEn    (regWrEn),
    .regWrAddr  (regWrAddr),
    .regWrData  (regWrData),
    .memAddr    (memAddr),
    .misalign   (misalignFlag)
  );

  assign illegalFlag = instrValid && ctrl.illegal;

  // R9: the flag only rises on a valid word
  p_illegal_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    illegalFlag |-> instrValid);

endmodule

// File: tb/rexec_core_tb.sv
module rexec_core_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        regWrEn;
  logic [4:0]  regWrAddr;
  logic [31:0] regWrData;
  logic [31:0] memAddr;
  logic        misalignFlag;
  logic        illegalFlag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rexec_core dut_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .memAddr(memAddr), .misalignFlag(misalignFlag), .illegalFlag(illegalFlag)
  );

  // {instr, expEn, expAddr, expData, expMemAddr}
  localparam int NVEC = 19;
  localparam logic [101:0] VEC [NVEC] = '{
    {32'h20010005, 1'b1, 5'd1,  32'h00000005, 32'h0},  // R5 addi r1=5
    {32'h2002FFFD, 1'b1, 5'd2,  32'hFFFFFFFD, 32'h0},  // R5 addi r2=-3
    {32'h00221820, 1'b1, 5'd3,  32'h00000002, 32'h0},  // R2 add
    {32'h00222022, 1'b1, 5'd4,  32'h00000008, 32'h0},  // R2 sub
    {32'h00222824, 1'b1, 5'd5,  32'h00000005, 32'h0},  // R3 and
    {32'h00223025, 1'b1, 5'd6,  32'hFFFFFFFD, 32'h0},  // R3 or
    {32'h00223827, 1'b1, 5'd7,  32'h00000002, 32'h0},  // R3 nor
    {32'h00024100, 1'b1, 5'd8,  32'hFFFFFFD0, 32'h0},  // R4 sll 4
    {32'h00024F02, 1'b1, 5'd9,  32'h0000000F, 32'h0},  // R4 srl 28
    {32'h00425020, 1'b1, 5'd10, 32'hFFFFFFFA, 32'h0},  // R2 add wraps
    {32'hAC810004, 1'b0, 5'd0,  32'h0,        32'd12}, // R6 sw r1,4(r4)
    {32'h8C8C0004, 1'b1, 5'd12, 32'h00000005, 32'd12}, // R6 lw r12,4(r4)
    {32'h8C8DFFFC, 1'b1, 5'd13, 32'h00000000, 32'd4},  // R6 lw neg offset
    {32'hAC82FFF8, 1'b0, 5'd0,  32'h0,        32'd0},  // R6 sw r2,-8(r4)
    {32'h8C0E0000, 1'b1, 5'd14, 32'hFFFFFFFD, 32'd0},  // R6 lw r14,0(r0)
    {32'h20200007, 1'b0, 5'd0,  32'h0,        32'h0},  // R7 addi to r0
    {32'h00007825, 1'b1, 5'd15, 32'h00000000, 32'h0},  // R7 r0 reads 0
    {32'h00210020, 1'b0, 5'd0,  32'h0,        32'h0},  // R7 add to r0
    {32'h00018020, 1'b1, 5'd16, 32'h00000005, 32'h0}   // R7 r0+r1
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] instr, input logic valid);
    @(negedge clk);
    instrWord  = instr;
    instrValid = valid;
    #2;
  endtask

  // reads a register through an OR to r0: value shows on regWrData
  task automatic peekReg(input int idx, input logic [31:0] exp, input string tag);
    apply((32'(idx) << 21) | 32'h25, 1'b1);
    chk(tag, regWrData, exp);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    // R1 reset state
    chk("R1 regWrEn idle", {31'b0, regWrEn}, 32'd0);
    chk("R1 illegal idle", {31'b0, illegalFlag}, 32'd0);
    chk("R1 misalign idle", {31'b0, misalignFlag}, 32'd0);
    peekReg(1, 32'h0, "R1 reg clear");
    apply(32'h8C00000C, 1'b1);
    chk("R1 mem clear", regWrData, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [101:0] v;
      v = VEC[i];
      apply(v[101:70], 1'b1);
      chk($sformatf("vec%0d regWrEn", i), {31'b0, regWrEn}, {31'b0, v[69]});
      if (v[69]) begin
        chk($sformatf("vec%0d regWrAddr", i), {27'b0, regWrAddr}, {27'b0, v[68:64]});
        chk($sformatf("vec%0d regWrData", i), regWrData, v[63:32]);
      end
      chk($sformatf("vec%0d memAddr", i), memAddr, v[31:0]);
      chk($sformatf("vec%0d flags", i), {30'b0, illegalFlag, misalignFlag}, 32'd0);
    end

    // R8 misaligned load: no write to r17
    apply(32'h8C910002, 1'b1);
    chk("R8 misalign load flag", {31'b0, misalignFlag}, 32'd1);
    chk("R8 misalign load wr", {31'b0, regWrEn}, 32'd0);
    chk("R8 misalign addr", memAddr, 32'd10);
    peekReg(17, 32'h0, "R8 r17 untouched");
    // R8 misaligned store to byte 1 must not touch word 0
    apply(32'hAC010001, 1'b1);
    chk("R8 misalign store flag", {31'b0, misalignFlag}, 32'd1);
    apply(32'h8C000000, 1'b1);
    chk("R8 word0 untouched", regWrData, 32'hFFFFFFFD);
    // R6 index wrap: byte 64 maps to word 0 with 16 words
    apply(32'h8C000040, 1'b1);
    chk("R6 index wrap", regWrData, 32'hFFFFFFFD);

    // R9 illegal opcode and funct
    apply(32'hFC000000, 1'b1);
    chk("R9 bad opcode flag", {31'b0, illegalFlag}, 32'd1);
    chk("R9 bad opcode wr", {31'b0, regWrEn}, 32'd0);
    apply(32'h0000083F, 1'b1);
    chk("R9 bad funct flag", {31'b0, illegalFlag}, 32'd1);
    chk("R9 bad funct wr", {31'b0, regWrEn}, 32'd0);
    peekReg(1, 32'h5, "R9 r1 kept");

    // R10 no strobe
    apply(32'h20010063, 1'b0);
    chk("R10 no write", {31'b0, regWrEn}, 32'd0);
    apply(32'hFC000000, 1'b0);
    chk("R10 no illegal", {31'b0, illegalFlag}, 32'd0);
    apply(32'hAC010001, 1'b0);
    chk("R10 no misalign", {31'b0, misalignFlag}, 32'd0);
    peekReg(1, 32'h5, "R10 r1 kept");

    // R1 reset again clears state written above
    @(negedge clk);
    instrValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    peekReg(3, 32'h0, "R1 reg cleared again");
    apply(32'h8C00000C, 1'b1);
    chk("R1 mem cleared again", regWrData, 32'h0);

    @(negedge clk);
    instrValid = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule